// File: doc/BRIEF.md
# Execution-Context Privilege Monitor

This block sits next to the memory bus of a small RISC-V processor and keeps track of which execution context is active. The three contexts are firmware, application and syscall. No control register sets the privilege level. It follows from where instructions are fetched and from which addresses are written.

After reset the core runs in firmware. The first instruction fetched from outside the firmware ROM moves the block into application mode, and it cannot return to firmware without a reset. An application asks for a syscall by writing anywhere inside a fixed trigger window. That write raises an interrupt request, which stays high until the processor acknowledges it. The acknowledge enters the syscall context, and an interrupt-return indication leaves it.

While this happens, the monitor gates reads of two protected regions: the device identifier and the device secret. It also watches every bus access for illegal use, including entry into a guard band at the bottom of firmware RAM that stands in for stack overflow. An illegal access sets a sticky fault flag.

Top module: `exec_ctx_monitor`

## Requirements
- R1: After a synchronous active-high reset, `mode` is 0 (firmware), and both `syscall_irq` and `fault` are 0.
- R2: A valid write to any address from 0xE1000000 to 0xE1FFFFFF sets `syscall_irq` on the next cycle. Reads or fetches in that window, and writes just outside it, do not set it. Once set, `syscall_irq` stays high until a cycle with `irq_ack` high.
- R3: A trigger write does not set `syscall_irq` while the request is already pending or while `mode` is 2 (syscall). A second trigger before the acknowledge is not queued.
- R4: In firmware mode (0), a valid instruction fetch outside ROM (0x00000000 to 0x00001FFF) changes `mode` to 1 (application) on the next cycle. A fetch inside ROM leaves `mode` at 0.
- R5: `mode` never returns to 0 without a reset. In mode 1, `irq_ack` with a pending request gives mode 2 on the next cycle. In mode 2, `irq_return` gives mode 1 on the next cycle.
- R6: A valid instruction fetch from ROM in mode 1 is illegal. ROM fetches in modes 0 and 2, and data reads of ROM in mode 1, are legal.
- R7: The identifier region is 0xC0000040 to 0xC0000047. For a valid read there, `ident_rd_en` is high in the same cycle in modes 0 and 2 and low in mode 1. A read of the region in mode 1 is illegal.
- R8: The secret region is 0xC0000000 to 0xC000001F. For a valid read there, `secret_rd_en` is high in the same cycle only in mode 0. A read of the region in mode 1 or mode 2 is illegal.
- R9: Any valid access to firmware RAM (0xD0000000 to 0xD0000FFF) in mode 1 is illegal. In modes 0 and 2, any access to the stack guard band (0xD0000000 to 0xD000000F) is illegal.
- R10: An illegal access sets `fault` on the cycle after it, not in the same cycle. `fault` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | Access is a write |
| bus_instr | input | 1 | Access is an instruction fetch |
| bus_addr | input | 32 | Byte address of the access |
| irq_ack | input | 1 | Processor accepts the syscall interrupt |
| irq_return | input | 1 | Processor returns from the interrupt handler |
| syscall_irq | output | 1 | Syscall interrupt request |
| mode | output | 2 | Current context: 0 firmware, 1 application, 2 syscall |
| ident_rd_en | output | 1 | Read enable for the identifier region |
| secret_rd_en | output | 1 | Read enable for the secret region |
| fault | output | 1 | Sticky illegal-access flag |

## Verification
The assertions check on every cycle the properties that need no knowledge of the address map:
- the context never falls back to firmware;
- a pending request holds until it is acknowledged;
- the syscall context holds no request;
- the fault flag stays set;
- each read gate opens only in a context that allows it.

Only the bench's scenarios can show that the address map itself is right. It probes every region boundary from both sides in each context. It also checks the one-cycle latency of the mode change, the request and the fault, and that a second trigger before the acknowledge leaves no extra request behind.

// File: rtl/exec_ctx_pkg.sv
package exec_ctx_pkg;

    typedef enum logic [1:0] {
        MODE_FW  = 2'd0,
        MODE_APP = 2'd1,
        MODE_SYS = 2'd2
    } mode_e;

    typedef struct packed {
        logic rom;
        logic fwram;
        logic guard;
        logic ident;
        logic secret;
        logic trig;
    } region_s;

    localparam int NUM_REGIONS = 6;
    localparam int IDX_ROM     = 0;
    localparam int IDX_FWRAM   = 1;
    localparam int IDX_GUARD   = 2;
    localparam int IDX_IDENT   = 3;
    localparam int IDX_SECRET  = 4;
    localparam int IDX_TRIG    = 5;

    function automatic logic in_window(input logic [31:0] addr,
                                       input logic [31:0] base,
                                       input logic [31:0] size);
        logic [32:0] off;
        off = {1'b0, addr} - {1'b0, base};
        return (addr >= base) && (off < {1'b0, size});
    endfunction

endpackage

// File: rtl/exec_ctx_decode.sv
module exec_ctx_decode
    import exec_ctx_pkg::*;
#(
    parameter int          AW          = 32,
    parameter logic [31:0] ROM_BASE    = 32'h0000_0000,
    parameter logic [31:0] ROM_SIZE    = 32'h0000_2000,
    parameter logic [31:0] FWRAM_BASE  = 32'hD000_0000,
    parameter logic [31:0] FWRAM_SIZE  = 32'h0000_1000,
    parameter logic [31:0] GUARD_SIZE  = 32'h0000_0010,
    parameter logic [31:0] IDENT_BASE  = 32'hC000_0040,
    parameter logic [31:0] IDENT_SIZE  = 32'h0000_0008,
    parameter logic [31:0] SECRET_BASE = 32'hC000_0000,
    parameter logic [31:0] SECRET_SIZE = 32'h0000_0020,
    parameter logic [31:0] TRIG_BASE   = 32'hE100_0000,
    parameter logic [31:0] TRIG_SIZE   = 32'h0100_0000
) (
    input  logic [AW-1:0] addr,
    output region_s       hits
);
    localparam logic [31:0] BASES [NUM_REGIONS] = '{
        ROM_BASE, FWRAM_BASE, FWRAM_BASE, IDENT_BASE, SECRET_BASE, TRIG_BASE
    };
    localparam logic [31:0] SIZES [NUM_REGIONS] = '{
        ROM_SIZE, FWRAM_SIZE, GUARD_SIZE, IDENT_SIZE, SECRET_SIZE, TRIG_SIZE
    };

    logic [NUM_REGIONS-1:0] hit_vec;
    logic [31:0]            addr32;

    assign addr32 = 32'(addr);

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_win
        assign hit_vec[i] = in_window(addr32, BASES[i], SIZES[i]);
    end

    always_comb begin
        hits.rom    = hit_vec[IDX_ROM];
        hits.fwram  = hit_vec[IDX_FWRAM];
        hits.guard  = hit_vec[IDX_GUARD];
        hits.ident  = hit_vec[IDX_IDENT];
        hits.secret = hit_vec[IDX_SECRET];
        hits.trig   = hit_vec[IDX_TRIG];
    end

endmodule

// File: rtl/exec_ctx_fsm.sv
module exec_ctx_fsm
    import exec_ctx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_valid,
    input  logic    bus_write,
    input  logic    bus_instr,
    input  region_s hits,
    input  logic    irq_ack,
    input  logic    irq_return,
    output mode_e   mode,
    output logic    irq_pend
);
    logic trig_wr;
    logic leave_fw;

    assign trig_wr  = bus_valid && bus_write && hits.trig;
    assign leave_fw = bus_valid && bus_instr && !hits.rom;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_FW;
            irq_pend <= 1'b0;
        end else begin
            if (irq_pend && irq_ack) begin
                irq_pend <= 1'b0;
            end else if (trig_wr && !irq_pend && mode != MODE_SYS) begin
                irq_pend <= 1'b1;
            end

            unique case (mode)
                MODE_FW:  if (leave_fw) mode <= MODE_APP;
                MODE_APP: if (irq_pend && irq_ack) mode <= MODE_SYS;
                MODE_SYS: if (irq_return) mode <= MODE_APP;
                default:  mode <= MODE_APP;
            endcase
        end
    end

    // R5: firmware context is left for good
    p_no_fw_return_r5: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_FW) |=> (mode != MODE_FW));

    // R5: only the three defined contexts occur
    p_mode_legal_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FW) || (mode == MODE_APP) || (mode == MODE_SYS));

    // R2: request holds until acknowledged
    p_irq_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && !irq_ack) |=> irq_pend);

    // R3: no request is raised while in the syscall context
    p_sys_no_irq_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SYS && !irq_return) |=> !irq_pend);

endmodule

// File: rtl/exec_ctx_guard.sv
module exec_ctx_guard
    import exec_ctx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_valid,
    input  logic    bus_write,
    input  logic    bus_instr,
    input  region_s hits,
    input  mode_e   mode,
    output logic    ident_rd_en,
    output logic    secret_rd_en,
    output logic    fault
);
    logic rd;
    logic bad_fetch, bad_ident, bad_secret, bad_ram, bad_stack;
    logic illegal;

    assign rd = bus_valid && !bus_write;

    assign ident_rd_en  = rd && hits.ident  && (mode != MODE_APP);
    assign secret_rd_en = rd && hits.secret && (mode == MODE_FW);

    always_comb begin
        bad_fetch  = bus_valid && bus_instr && hits.rom && (mode == MODE_APP);
        bad_ident  = rd && hits.ident  && (mode == MODE_APP);
        bad_secret = rd && hits.secret && (mode != MODE_FW);
        bad_ram    = bus_valid && hits.fwram && (mode == MODE_APP);
        bad_stack  = bus_valid && hits.guard && (mode != MODE_APP);
        illegal    = bad_fetch || bad_ident || bad_secret || bad_ram || bad_stack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault <= 1'b0;
        end else if (illegal) begin
            fault <= 1'b1;
        end
    end

    // R10: the fault flag is sticky
    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    // R7: identifier gate never opens in application context
    p_ident_gate_r7: assert property (@(posedge clk) disable iff (rst)
        ident_rd_en |-> (mode != MODE_APP));

    // R8: secret gate opens only in firmware context
    p_secret_gate_r8: assert property (@(posedge clk) disable iff (rst)
        secret_rd_en |-> (mode == MODE_FW));

endmodule

// File: rtl/exec_ctx_monitor.sv
module exec_ctx_monitor
    import exec_ctx_pkg::*;
#(
    parameter int          AW          = 32,
    parameter logic [31:0] ROM_BASE    = 32'h0000_0000,
    parameter logic [31:0] ROM_SIZE    = 32'h0000_2000,
    parameter logic [31:0] FWRAM_BASE  = 32'hD000_0000,
    parameter logic [31:0] FWRAM_SIZE  = 32'h0000_1000,
    parameter logic [31:0] GUARD_SIZE  = 32'h0000_0010,
    parameter logic [31:0] IDENT_BASE  = 32'hC000_0040,
    parameter logic [31:0] IDENT_SIZE  = 32'h0000_0008,
    parameter logic [31:0] SECRET_BASE = 32'hC000_0000,
    parameter logic [31:0] SECRET_SIZE = 32'h0000_0020,
    parameter logic [31:0] TRIG_BASE   = 32'hE100_0000,
    parameter logic [31:0] TRIG_SIZE   = 32'h0100_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic          bus_instr,
    input  logic [AW-1:0] bus_addr,
    input  logic          irq_ack,
    input  logic          irq_return,
    output logic          syscall_irq,
    output logic [1:0]    mode,
    output logic          ident_rd_en,
    output logic          secret_rd_en,
    output logic          fault
);
    region_s hits;
    mode_e   cur_mode;

    exec_ctx_decode #(
        .AW(AW),
        .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE),
        .FWRAM_BASE(FWRAM_BASE), .FWRAM_SIZE(FWRAM_SIZE),
        .GUARD_SIZE(GUARD_SIZE),
        .IDENT_BASE(IDENT_BASE), .IDENT_SIZE(IDENT_SIZE),
        .SECRET_BASE(SECRET_BASE), .SECRET_SIZE(SECRET_SIZE),
        .TRIG_BASE(TRIG_BASE), .TRIG_SIZE(TRIG_SIZE)
    ) u_decode (
        .addr(bus_addr),
        .hits(hits)
    );

    exec_ctx_fsm u_fsm (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_instr(bus_instr),
        .hits(hits),
        .irq_ack(irq_ack), .irq_return(irq_return),
        .mode(cur_mode), .irq_pend(syscall_irq)
    );

    exec_ctx_guard u_guard (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_instr(bus_instr),
        .hits(hits), .mode(cur_mode),
        .ident_rd_en(ident_rd_en), .secret_rd_en(secret_rd_en),
        .fault(fault)
    );

    assign mode = cur_mode;

    // R3: acknowledge clears the request, leaving nothing queued
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (syscall_irq && irq_ack) |=> !syscall_irq);

endmodule

// File: tb/tb_exec_ctx_monitor.sv
module tb_exec_ctx_monitor;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write, bus_instr;
    logic [31:0] bus_addr;
    logic        irq_ack, irq_return;
    logic        syscall_irq;
    logic [1:0]  mode;
    logic        ident_rd_en, secret_rd_en, fault;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    exec_ctx_monitor dut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_instr(bus_instr),
        .bus_addr(bus_addr),
        .irq_ack(irq_ack), .irq_return(irq_return),
        .syscall_irq(syscall_irq), .mode(mode),
        .ident_rd_en(ident_rd_en), .secret_rd_en(secret_rd_en),
        .fault(fault)
    );

    // {mode[2], write, fetch, addr[32], exp_fault, exp_ident, exp_secret}
    localparam int NV = 27;
    localparam logic [38:0] VEC [NV] = '{
        {2'd1, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b0}, // R6
        {2'd1, 1'b0, 1'b1, 32'h0000_1FFF, 1'b1, 1'b0, 1'b0}, // R6
        {2'd1, 1'b0, 1'b1, 32'h0000_2000, 1'b0, 1'b0, 1'b0}, // R6
        {2'd0, 1'b0, 1'b1, 32'h0000_1FFF, 1'b0, 1'b0, 1'b0}, // R6
        {2'd2, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0}, // R6
        {2'd1, 1'b0, 1'b0, 32'hC000_0040, 1'b1, 1'b0, 1'b0}, // R7
        {2'd1, 1'b0, 1'b0, 32'hC000_0047, 1'b1, 1'b0, 1'b0}, // R7
        {2'd1, 1'b0, 1'b0, 32'hC000_0048, 1'b0, 1'b0, 1'b0}, // R7
        {2'd1, 1'b0, 1'b0, 32'hC000_003F, 1'b0, 1'b0, 1'b0}, // R7
        {2'd2, 1'b0, 1'b0, 32'hC000_0040, 1'b0, 1'b1, 1'b0}, // R7
        {2'd2, 1'b0, 1'b0, 32'hC000_0047, 1'b0, 1'b1, 1'b0}, // R7
        {2'd0, 1'b0, 1'b0, 32'hC000_0047, 1'b0, 1'b1, 1'b0}, // R7
        {2'd2, 1'b0, 1'b0, 32'hC000_0048, 1'b0, 1'b0, 1'b0}, // R7
        {2'd0, 1'b0, 1'b0, 32'hC000_0000, 1'b0, 1'b0, 1'b1}, // R8
        {2'd0, 1'b0, 1'b0, 32'hC000_001F, 1'b0, 1'b0, 1'b1}, // R8
        {2'd0, 1'b0, 1'b0, 32'hC000_0020, 1'b0, 1'b0, 1'b0}, // R8
        {2'd2, 1'b0, 1'b0, 32'hC000_0000, 1'b1, 1'b0, 1'b0}, // R8
        {2'd1, 1'b0, 1'b0, 32'hC000_001F, 1'b1, 1'b0, 1'b0}, // R8
        {2'd1, 1'b0, 1'b0, 32'hD000_0FFF, 1'b1, 1'b0, 1'b0}, // R9
        {2'd1, 1'b0, 1'b0, 32'hD000_1000, 1'b0, 1'b0, 1'b0}, // R9
        {2'd1, 1'b1, 1'b0, 32'hCFFF_FFFF, 1'b0, 1'b0, 1'b0}, // R9
        {2'd1, 1'b1, 1'b0, 32'hD000_0010, 1'b1, 1'b0, 1'b0}, // R9
        {2'd0, 1'b1, 1'b0, 32'hD000_000F, 1'b1, 1'b0, 1'b0}, // R9
        {2'd0, 1'b1, 1'b0, 32'hD000_0010, 1'b0, 1'b0, 1'b0}, // R9
        {2'd0, 1'b0, 1'b0, 32'hD000_0FFF, 1'b0, 1'b0, 1'b0}, // R9
        {2'd2, 1'b0, 1'b0, 32'hD000_0000, 1'b1, 1'b0, 1'b0}, // R9
        {2'd2, 1'b1, 1'b0, 32'hD000_0010, 1'b0, 1'b0, 1'b0}  // R9
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        bus_valid = 1'b0; bus_write = 1'b0; bus_instr = 1'b0;
        bus_addr = 32'h8000_0000; irq_ack = 1'b0; irq_return = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive one access in the low phase; registered effect visible at next negedge
    task automatic access(input logic w, input logic f, input logic [31:0] a);
        bus_valid = 1'b1; bus_write = w; bus_instr = f; bus_addr = a;
        #2;
    endtask

    task automatic finish_cycle();
        @(negedge clk);
        idle();
    endtask

    task automatic enter_mode(input logic [1:0] m);
        do_reset();
        if (m != 2'd0) begin
            access(1'b0, 1'b1, 32'h4000_0000);
            finish_cycle();
        end
        if (m == 2'd2) begin
            access(1'b1, 1'b0, 32'hE100_0000);
            finish_cycle();
            irq_ack = 1'b1;
            @(negedge clk);
            idle();
        end
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle();
        do_reset();
        #1;
        chk(32'(mode), 0, "R1 mode after reset");
        chk(32'(syscall_irq), 0, "R1 irq after reset");
        chk(32'(fault), 0, "R1 fault after reset");

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [38:0] v;
            v = VEC[i];
            enter_mode(v[38:37]);
            chk(32'(mode), 32'(v[38:37]), $sformatf("R5 setup mode v%0d", i));
            access(v[36], v[35], v[34:3]);
            chk(32'(ident_rd_en), 32'(v[1]), $sformatf("R7 ident gate v%0d", i));
            chk(32'(secret_rd_en), 32'(v[0]), $sformatf("R8 secret gate v%0d", i));
            chk(32'(fault), 0, $sformatf("R10 fault not same cycle v%0d", i));
            finish_cycle();
            chk(32'(fault), 32'(v[2]), $sformatf("R6/R9 fault v%0d", i));
        end

        // R4: fetch inside ROM keeps firmware, outside moves to application
        do_reset();
        access(1'b0, 1'b1, 32'h0000_1FFF);
        finish_cycle();
        chk(32'(mode), 0, "R4 ROM fetch stays firmware");
        access(1'b0, 1'b1, 32'h0000_2000);
        chk(32'(mode), 0, "R4 mode unchanged before edge");
        finish_cycle();
        chk(32'(mode), 1, "R4 outside fetch enters application");

        // R2: trigger window boundaries
        access(1'b0, 1'b0, 32'hE100_0000); finish_cycle();
        chk(32'(syscall_irq), 0, "R2 read in window no irq");
        access(1'b0, 1'b1, 32'hE100_0000); finish_cycle();
        chk(32'(syscall_irq), 0, "R2 fetch in window no irq");
        access(1'b1, 1'b0, 32'hE0FF_FFFF); finish_cycle();
        chk(32'(syscall_irq), 0, "R2 write below window no irq");
        access(1'b1, 1'b0, 32'hE200_0000); finish_cycle();
        chk(32'(syscall_irq), 0, "R2 write above window no irq");
        access(1'b1, 1'b0, 32'hE1FF_FFFF);
        chk(32'(syscall_irq), 0, "R2 irq not before edge");
        finish_cycle();
        chk(32'(syscall_irq), 1, "R2 write at top of window raises irq");
        repeat (3) @(negedge clk);
        chk(32'(syscall_irq), 1, "R2 irq holds until ack");

        // R3: second trigger while pending is not queued
        access(1'b1, 1'b0, 32'hE100_0000); finish_cycle();
        chk(32'(syscall_irq), 1, "R3 pending irq still set");
        irq_ack = 1'b1;
        @(negedge clk); idle();
        chk(32'(syscall_irq), 0, "R3 ack clears, nothing queued");
        chk(32'(mode), 2, "R5 ack enters syscall");
        @(negedge clk);
        chk(32'(syscall_irq), 0, "R3 no queued irq after ack");
        access(1'b1, 1'b0, 32'hE100_0000); finish_cycle();
        chk(32'(syscall_irq), 0, "R3 trigger ignored in syscall");
        chk(32'(mode), 2, "R5 syscall holds without return");
        irq_return = 1'b1;
        @(negedge clk); idle();
        chk(32'(mode), 1, "R5 return goes to application");
        access(1'b0, 1'b0, 32'h0000_0000); finish_cycle();
        chk(32'(mode), 1, "R5 ROM data read keeps application");
        chk(32'(fault), 0, "R6 ROM data read in application legal");

        // R10: sticky fault, cleared only by reset
        access(1'b0, 1'b1, 32'h0000_0100); finish_cycle();
        chk(32'(fault), 1, "R10 fault set after illegal fetch");
        chk(32'(mode), 1, "R5 illegal fetch keeps application");
        repeat (5) @(negedge clk);
        chk(32'(fault), 1, "R10 fault stays set");
        do_reset();
        #1;
        chk(32'(fault), 0, "R10 reset clears fault");
        chk(32'(mode), 0, "R1 reset returns to firmware");

        // R2: trigger in firmware and ack there keeps firmware
        access(1'b1, 1'b0, 32'hE100_0000); finish_cycle();
        chk(32'(syscall_irq), 1, "R2 trigger in firmware raises irq");
        irq_ack = 1'b1;
        @(negedge clk); idle();
        chk(32'(syscall_irq), 0, "R2 ack clears irq");
        chk(32'(mode), 0, "R5 ack in firmware keeps firmware");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule